// File: doc/BRIEF.md
# Register-Mapped Random Number Generator Controller

This block is a random number generator controller that software drives through a simple 32-bit register bus (address, write strobe, read strobe, write data, registered read data). Software issues one of three commands: do nothing, produce a block of random bits, or reseed. The core walks through distinct seeding and generating phases and reports each in a status word. Results land in eight readable 32-bit data words, either as a 128-bit or a 256-bit block. Completion raises a sticky flag that software clears by writing ones, and a level interrupt can be routed from that flag.

The entropy source is a seedable 64-bit xorshift generator, so every result is reproducible from reset. The generator is stirred during each seed phase and stepped each cycle while generating. Each 56-bit round costs a programmable number of core cycles. The core counts the 16-byte units it hands out and reseeds on its own once a programmed limit is reached. After reset it seeds itself before it accepts any command.

Top module: `trng_ctrl_core`

## Requirements
- R1: After reset the status word reads 0x80000000, with reseeding set and seeded clear. After SEED_CYCLES cycles it reads 0x00000200 (seeded only, idle) and the seed-done flag, bit 1 of the flag register at 0x14, is set.
- R2: The register at 0xF0 reads 0x000046BC. An unmapped offset such as 0x80 reads 0.
- R3: Writing 1 to the command register at 0x00 while idle sets status bit 30 (generating). The random-ready flag, bit 0 at 0x14, and with it the interrupt, rises exactly ROUNDS×ROUND_CYCLES cycles after the write edge. ROUNDS is ceil(bits/56): 5 for 256 bits and 3 for 128 bits.
- R4: With bit 3 of the mode register at 0x08 set, a request fills all eight data words at 0x20..0x3C. The words are not all zero, and two successive requests give different data.
- R5: With mode bit 3 clear, data words 4..7 (0x30..0x3C) read 0 and words 0..3 are not all zero.
- R6: Writing 2 to the command register while idle makes the status read 0x80000200 for SEED_CYCLES cycles. After that the seed-done flag is set and the status returns to 0x00000200. Seeded never clears once set.
- R7: A command written while generating or reseeding is ignored. A running 256-bit request still completes at its normal cycle and the core returns to idle with no reseed.
- R8: Writing to the flag register at 0x14 clears each flag whose data bit is 1 and leaves the flags written with 0 alone. Flags are set even while all interrupt enables are 0.
- R9: The irq output is high exactly when global enable bit 31 of 0x10 is set and either (bit 0 enable and random-ready) or (bit 1 enable and seed-done) holds.
- R10: The register at 0x60 holds a limit of 16-byte units, where a 128-bit request counts 1 and a 256-bit request counts 2. Writing it clears the running count. When a finished request brings the count to the limit or above, the core enters reseeding at once. A limit of 0 disables this.
- R11: After a fresh reset and self-seed, the first 256-bit request returns the same eight words as the first one after any earlier reset.
- R12: Command 0 changes neither the status nor the data words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, active high |

## Verification
Requests are issued in both output sizes, so the measured round counts (five against three) and the zeroed upper data words tell the two size paths apart. Back-to-back requests with unchanged settings show the generator advances between blocks. A second reset shows the sequence restarts identically. Commands written during a running request check that the busy guard leaves the completion cycle untouched. Auto-reseed is driven with limits reached by 128-bit units and by 256-bit double units, which separates unit weighting from plain request counting.

// File: rtl/trng_pkg.sv
// Shared offsets, bit positions and types for the random number controller.
// Assumes byte addressing with 32-bit aligned registers.
package trng_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int STATE_W = 64;

    localparam logic [ADDR_W-1:0] OFF_CMD   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_MODE  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_FLAG  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_LIMIT = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_VER   = 8'hF0;

    localparam int ST_SEEDED  = 9;
    localparam int ST_GEN     = 30;
    localparam int ST_RESEED  = 31;
    localparam int MODE_FULL  = 3;
    localparam int IE_GLOBAL  = 31;
    localparam int IE_SEED    = 1;
    localparam int IE_READY   = 0;
    localparam int FL_READY   = 0;
    localparam int FL_SEED    = 1;

    localparam logic [DATA_W-1:0] VERSION_WORD = 32'h0000_46BC;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEED = 2'd1,
        PH_GEN  = 2'd2
    } phase_e;

    localparam logic [1:0] CMD_NOP  = 2'd0;
    localparam logic [1:0] CMD_RAND = 2'd1;
    localparam logic [1:0] CMD_SEED = 2'd2;
endpackage

// File: rtl/trng_prng.sv
// Deterministic stand-in for the entropy source: a 64-bit xorshift state.
// 'stir' mixes in a constant (seed phase), 'step' advances it (generation).
// Assumes OUT_W <= 64.
module trng_prng
    import trng_pkg::*;
#(
    parameter int                 OUT_W      = 56,
    parameter logic [STATE_W-1:0] SEED_VALUE = 64'h1234_5678_9ABC_DEF1,
    parameter logic [STATE_W-1:0] STIR_CONST = 64'h9E37_79B9_7F4A_7C15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stir,
    input  logic             step,
    output logic [OUT_W-1:0] sample_o
);
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] stirred;

    function automatic logic [STATE_W-1:0] xorshift(input logic [STATE_W-1:0] x);
        logic [STATE_W-1:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    // Stirred value, kept away from the all-zero lock-up state.
    always_comb begin
        stirred = xorshift(state_q) ^ STIR_CONST;
        if (stirred == '0) stirred = STIR_CONST;
    end

    // State register: reset to the seed value, stir or step on request.
    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= SEED_VALUE;
        else if (stir) state_q <= stirred;
        else if (step) state_q <= xorshift(state_q);
    end

    assign sample_o = state_q[OUT_W-1:0];
endmodule

// File: rtl/trng_seq.sv
// Phase sequencer: self-seed after reset, command-driven seed and generate,
// round timing, and the 16-byte unit counter that forces automatic reseeds.
// Assumes commands arrive as single-cycle strobes.
module trng_seq
    import trng_pkg::*;
#(
    parameter int ROUND_CYCLES   = 1024,
    parameter int SEED_CYCLES    = 1024,
    parameter int BITS_PER_ROUND = 56,
    parameter int OUT_BITS       = 256,
    parameter int LIMIT_W        = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [1:0]         cmd_code,
    input  logic               mode_full,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               limit_wr,
    output phase_e             phase_o,
    output logic               seeded_o,
    output logic               round_tick_o,
    output logic               gen_done_o,
    output logic               seed_done_o,
    output logic               auto_hit_o,
    output logic               gen_full_o
);
    localparam int MAX_CYC     = (ROUND_CYCLES > SEED_CYCLES) ? ROUND_CYCLES : SEED_CYCLES;
    localparam int CNT_W       = $clog2(MAX_CYC + 1);
    localparam int ROUNDS_FULL = (OUT_BITS + BITS_PER_ROUND - 1) / BITS_PER_ROUND;
    localparam int ROUNDS_HALF = (OUT_BITS / 2 + BITS_PER_ROUND - 1) / BITS_PER_ROUND;
    localparam int RND_W       = $clog2(ROUNDS_FULL + 1);

    phase_e             phase_q;
    logic [CNT_W-1:0]   cyc_q;
    logic [RND_W-1:0]   rnd_q;
    logic               seeded_q;
    logic               full_q;
    logic [LIMIT_W-1:0] units_q;
    logic [LIMIT_W:0]   units_sum;
    logic [RND_W-1:0]   last_rnd;
    logic               seed_last;
    logic               round_last;
    logic               start_gen;
    logic               start_seed;

    // Command acceptance: only in the idle phase.
    assign start_gen  = cmd_wr && (phase_q == PH_IDLE) && (cmd_code == CMD_RAND);
    assign start_seed = cmd_wr && (phase_q == PH_IDLE) && (cmd_code == CMD_SEED);

    // End-of-phase detection for seed and each generation round.
    assign seed_last  = (phase_q == PH_SEED) && (cyc_q == CNT_W'(SEED_CYCLES - 1));
    assign round_last = (phase_q == PH_GEN)  && (cyc_q == CNT_W'(ROUND_CYCLES - 1));
    assign last_rnd   = full_q ? RND_W'(ROUNDS_FULL - 1) : RND_W'(ROUNDS_HALF - 1);

    // Running unit count including the request that is finishing now.
    assign units_sum  = {1'b0, units_q} + (full_q ? (LIMIT_W+1)'(2) : (LIMIT_W+1)'(1));
    assign auto_hit_o = (limit != '0) && (units_sum >= {1'b0, limit});

    // Phase, cycle and round counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_SEED;
            cyc_q    <= '0;
            rnd_q    <= '0;
            seeded_q <= 1'b0;
            full_q   <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    cyc_q <= '0;
                    rnd_q <= '0;
                    if (start_gen) begin
                        phase_q <= PH_GEN;
                        full_q  <= mode_full;
                    end else if (start_seed) begin
                        phase_q <= PH_SEED;
                    end
                end
                PH_SEED: begin
                    if (seed_last) begin
                        phase_q  <= PH_IDLE;
                        seeded_q <= 1'b1;
                        cyc_q    <= '0;
                    end else begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
                PH_GEN: begin
                    if (round_last) begin
                        cyc_q <= '0;
                        if (rnd_q == last_rnd) begin
                            phase_q <= auto_hit_o ? PH_SEED : PH_IDLE;
                            rnd_q   <= '0;
                        end else begin
                            rnd_q <= rnd_q + 1'b1;
                        end
                    end else begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Unit counter: cleared on a limit write or when it forces a reseed.
    always_ff @(posedge clk) begin
        if (!rst_n)          units_q <= '0;
        else if (limit_wr)   units_q <= '0;
        else if (gen_done_o) units_q <= auto_hit_o ? '0 : units_sum[LIMIT_W-1:0];
    end

    assign phase_o      = phase_q;
    assign seeded_o     = seeded_q;
    assign round_tick_o = round_last;
    assign gen_done_o   = round_last && (rnd_q == last_rnd);
    assign seed_done_o  = seed_last;
    assign gen_full_o   = full_q;
endmodule

// File: rtl/trng_outbuf.sv
// Collects generator samples round by round and publishes them as data
// words at the end of a request; upper half masked in the short mode.
// Assumes OUT_BITS is a multiple of 2*WORD_W.
module trng_outbuf #(
    parameter int OUT_BITS       = 256,
    parameter int BITS_PER_ROUND = 56,
    parameter int WORD_W         = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      round_tick,
    input  logic                      gen_done,
    input  logic                      gen_full,
    input  logic [BITS_PER_ROUND-1:0] sample,
    output logic [OUT_BITS-1:0]       words_o
);
    localparam int NWORDS = OUT_BITS / WORD_W;
    localparam int HALF   = NWORDS / 2;

    logic [OUT_BITS-1:0] acc_q;
    logic [OUT_BITS-1:0] acc_next;
    logic [OUT_BITS-1:0] data_q;
    logic                full_q;

    // Next accumulator value: shift in one round of samples.
    assign acc_next = {acc_q[OUT_BITS-BITS_PER_ROUND-1:0], sample};

    // Accumulator and published data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (round_tick) acc_q <= acc_next;
            if (gen_done) begin
                data_q <= acc_next;
                full_q <= gen_full;
            end
        end
    end

    // Word view: lower half always visible, upper half only for full size.
    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        if (i < HALF) begin : g_low
            assign words_o[i*WORD_W +: WORD_W] = data_q[i*WORD_W +: WORD_W];
        end else begin : g_high
            assign words_o[i*WORD_W +: WORD_W] = full_q ? data_q[i*WORD_W +: WORD_W] : '0;
        end
    end
endmodule

// File: rtl/trng_ctrl_core.sv
// Register front end of the random number controller: decodes bus writes
// into commands and settings, keeps the write-one-to-clear flags, drives
// the level interrupt and returns registered read data.
// Assumes one access per strobe and aligned 32-bit offsets.
module trng_ctrl_core
    import trng_pkg::*;
#(
    parameter int                 ROUND_CYCLES   = 1024,
    parameter int                 SEED_CYCLES    = 1024,
    parameter int                 BITS_PER_ROUND = 56,
    parameter int                 OUT_BITS       = 256,
    parameter int                 LIMIT_W        = 16,
    parameter logic [STATE_W-1:0] SEED_VALUE     = 64'h1234_5678_9ABC_DEF1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int NWORDS = OUT_BITS / DATA_W;
    localparam int WSEL_W = $clog2(NWORDS);
    localparam logic [ADDR_W-1:0] OFF_DATA_LO = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_DATA_HI = OFF_DATA_LO + ADDR_W'(4 * (NWORDS - 1));

    phase_e                    phase;
    logic                      seeded;
    logic                      round_tick;
    logic                      gen_done;
    logic                      seed_done;
    logic                      auto_hit;
    logic                      gen_full;
    logic [BITS_PER_ROUND-1:0] sample;
    logic [OUT_BITS-1:0]       words;

    logic [DATA_W-1:0]  ie_q;
    logic               mode_full_q;
    logic [LIMIT_W-1:0] limit_q;
    logic [1:0]         flag_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  stat_word;
    logic               wr_cmd, wr_mode, wr_ie, wr_flag, wr_limit;
    logic [WSEL_W-1:0]  wsel;

    // Write decode.
    assign wr_cmd   = bus_wr && (bus_addr == OFF_CMD);
    assign wr_mode  = bus_wr && (bus_addr == OFF_MODE);
    assign wr_ie    = bus_wr && (bus_addr == OFF_IEN);
    assign wr_flag  = bus_wr && (bus_addr == OFF_FLAG);
    assign wr_limit = bus_wr && (bus_addr == OFF_LIMIT);

    trng_seq #(
        .ROUND_CYCLES  (ROUND_CYCLES),
        .SEED_CYCLES   (SEED_CYCLES),
        .BITS_PER_ROUND(BITS_PER_ROUND),
        .OUT_BITS      (OUT_BITS),
        .LIMIT_W       (LIMIT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (wr_cmd),
        .cmd_code    (bus_wdata[1:0]),
        .mode_full   (mode_full_q),
        .limit       (limit_q),
        .limit_wr    (wr_limit),
        .phase_o     (phase),
        .seeded_o    (seeded),
        .round_tick_o(round_tick),
        .gen_done_o  (gen_done),
        .seed_done_o (seed_done),
        .auto_hit_o  (auto_hit),
        .gen_full_o  (gen_full)
    );

    trng_prng #(
        .OUT_W     (BITS_PER_ROUND),
        .SEED_VALUE(SEED_VALUE)
    ) u_prng (
        .clk     (clk),
        .rst_n   (rst_n),
        .stir    (phase == PH_SEED),
        .step    (phase == PH_GEN),
        .sample_o(sample)
    );

    trng_outbuf #(
        .OUT_BITS      (OUT_BITS),
        .BITS_PER_ROUND(BITS_PER_ROUND),
        .WORD_W        (DATA_W)
    ) u_outbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .round_tick(round_tick),
        .gen_done  (gen_done),
        .gen_full  (gen_full),
        .sample    (sample),
        .words_o   (words)
    );

    // Software settings: interrupt enables, output size, reseed limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q        <= '0;
            mode_full_q <= 1'b0;
            limit_q     <= '0;
        end else begin
            if (wr_ie)    ie_q        <= bus_wdata;
            if (wr_mode)  mode_full_q <= bus_wdata[MODE_FULL];
            if (wr_limit) limit_q     <= bus_wdata[LIMIT_W-1:0];
        end
    end

    // Sticky flags: set by completions, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q[FL_READY] <= gen_done  | (flag_q[FL_READY] & ~(wr_flag & bus_wdata[FL_READY]));
            flag_q[FL_SEED]  <= seed_done | (flag_q[FL_SEED]  & ~(wr_flag & bus_wdata[FL_SEED]));
        end
    end

    // Status word assembly.
    always_comb begin
        stat_word            = '0;
        stat_word[ST_SEEDED] = seeded;
        stat_word[ST_GEN]    = (phase == PH_GEN);
        stat_word[ST_RESEED] = (phase == PH_SEED);
    end

    assign wsel = bus_addr[WSEL_W+1:2];

    // Read multiplexer.
    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFF_STAT:  rd_mux = stat_word;
            OFF_MODE:  rd_mux[MODE_FULL] = mode_full_q;
            OFF_IEN:   rd_mux = ie_q;
            OFF_FLAG:  rd_mux[1:0] = flag_q;
            OFF_LIMIT: rd_mux[LIMIT_W-1:0] = limit_q;
            OFF_VER:   rd_mux = VERSION_WORD;
            default: begin
                if (bus_addr >= OFF_DATA_LO && bus_addr <= OFF_DATA_HI && bus_addr[1:0] == 2'b00)
                    rd_mux = words[wsel*DATA_W +: DATA_W];
            end
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign irq = ie_q[IE_GLOBAL] &
                 ((ie_q[IE_READY] & flag_q[FL_READY]) | (ie_q[IE_SEED] & flag_q[FL_SEED]));
endmodule

// File: rtl/trng_ctrl_core_chk.sv
// Property checker for the random number controller, attached by bind.
// Observes bus inputs, the interrupt and the sequencer's internal strobes.
module trng_ctrl_core_chk
    import trng_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [1:0]        wd_low,
    input logic              irq,
    input phase_e            phase,
    input logic              ie_global,
    input logic [1:0]        flags,
    input logic              seeded,
    input logic              gen_done,
    input logic              auto_hit
);
    logic in_gen, in_seed, cmd_wr;
    assign in_gen  = (phase == PH_GEN);
    assign in_seed = (phase == PH_SEED);
    assign cmd_wr  = bus_wr && (bus_addr == OFF_CMD);

    // R3: generation only starts from a random command written while idle.
    assert_gen_from_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_gen) |-> $past(cmd_wr && wd_low == CMD_RAND && phase == PH_IDLE));

    // R3: a finished request leaves the ready flag set.
    assert_done_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gen_done |=> flags[FL_READY]);

    // R6: seeded never drops once reached.
    assert_seeded_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seeded |=> seeded);

    // R7: a command during a running request does not end it early.
    assert_busy_cmd_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gen && cmd_wr && !gen_done) |=> in_gen);

    // R8: writing one to the ready flag clears it unless a completion coincides.
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_FLAG && wd_low[FL_READY] && !gen_done) |=> !flags[FL_READY]);

    // R9: with the global enable off the interrupt stays low.
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_global |-> !irq);

    // R10: reaching the unit limit moves straight into reseeding.
    assert_auto_reseed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_done && auto_hit) |=> in_seed);
endmodule

bind trng_ctrl_core trng_ctrl_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .wd_low   (bus_wdata[1:0]),
    .irq      (irq),
    .phase    (phase),
    .ie_global(ie_q[trng_pkg::IE_GLOBAL]),
    .flags    (flag_q),
    .seeded   (seeded),
    .gen_done (gen_done),
    .auto_hit (auto_hit)
);

// File: tb/trng_ctrl_core_tb.sv
// Directed bench for the random number controller, one task per scenario.
module trng_ctrl_core_tb;
    localparam int RC = 32;
    localparam int SC = 40;
    localparam logic [31:0] ST_IDLE = 32'h0000_0200;
    localparam logic [31:0] ST_GENS = 32'h4000_0200;
    localparam logic [31:0] ST_RSD  = 32'h8000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc_ctr = 0;
    int t_wr = 0;
    logic [31:0] first_words [8];
    logic [31:0] cur_words [8];

    trng_ctrl_core #(.ROUND_CYCLES(RC), .SEED_CYCLES(SC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc_ctr <= cyc_ctr + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 t_wr = cyc_ctr;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_irq(output int n);
        int guard = 0;
        while (!irq && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        n = cyc_ctr - t_wr;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            bus_read(8'h04, s);
            if (s == ST_IDLE) break;
        end
    endtask

    task automatic read_words();
        for (int i = 0; i < 8; i++) bus_read(8'h20 + 8'(4 * i), cur_words[i]);
    endtask

    task automatic run_gen(input bit full, output int n);
        bus_write(8'h08, full ? 32'h8 : 32'h0);
        bus_write(8'h10, 32'h8000_0001);
        bus_write(8'h14, 32'h1);
        bus_write(8'h00, 32'h1);
        wait_irq(n);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(8'h04, v);
        chk(v == 32'h8000_0000, "R1 status while self-seeding", v, 32'h8000_0000);
        repeat (SC) @(negedge clk);
        bus_read(8'h04, v);
        chk(v == ST_IDLE, "R1 status after self-seed", v, ST_IDLE);
        bus_read(8'h14, v);
        chk(v == 32'h2, "R1 seed-done flag", v, 32'h2);
        bus_read(8'hF0, v);
        chk(v == 32'h46BC, "R2 version", v, 32'h46BC);
        bus_read(8'h80, v);
        chk(v == 32'h0, "R2 unmapped", v, 32'h0);
    endtask

    task automatic t_gen256();
        int n;
        bit nz;
        bit diff;
        run_gen(1'b1, n);
        chk(n == 5 * RC, "R3 256-bit duration", n, 5 * RC);
        read_words();
        nz = 1'b0;
        for (int i = 0; i < 8; i++) begin
            first_words[i] = cur_words[i];
            if (cur_words[i] != 0) nz = 1'b1;
        end
        chk(nz, "R4 words not all zero", cur_words[7], 32'h1);
        run_gen(1'b1, n);
        read_words();
        diff = 1'b0;
        for (int i = 0; i < 8; i++) if (cur_words[i] != first_words[i]) diff = 1'b1;
        chk(diff, "R4 successive requests differ", cur_words[0], first_words[0]);
    endtask

    task automatic t_status_gen();
        logic [31:0] v;
        bus_write(8'h00, 32'h1);
        bus_read(8'h04, v);
        chk(v == ST_GENS, "R3 generating status", v, ST_GENS);
        wait_idle();
    endtask

    task automatic t_gen128();
        int n;
        bit nz;
        run_gen(1'b0, n);
        chk(n == 3 * RC, "R3 128-bit duration", n, 3 * RC);
        read_words();
        nz = 1'b0;
        for (int i = 0; i < 4; i++) if (cur_words[i] != 0) nz = 1'b1;
        chk(nz, "R5 low words not all zero", cur_words[0], 32'h1);
        for (int i = 4; i < 8; i++)
            chk(cur_words[i] == 0, "R5 upper word zero", cur_words[i], 32'h0);
    endtask

    task automatic t_busy_ignore();
        int t0, n;
        logic [31:0] v;
        bus_write(8'h08, 32'h8);
        bus_write(8'h10, 32'h8000_0001);
        bus_write(8'h14, 32'h3);
        bus_write(8'h00, 32'h1);
        t0 = t_wr;
        bus_write(8'h00, 32'h2);
        bus_write(8'h00, 32'h1);
        t_wr = t0;
        wait_irq(n);
        chk(n == 5 * RC, "R7 busy command leaves duration", n, 5 * RC);
        bus_read(8'h04, v);
        chk(v == ST_IDLE, "R7 no reseed after ignored command", v, ST_IDLE);
    endtask

    task automatic t_reseed();
        logic [31:0] v;
        bus_write(8'h10, 32'h0);
        bus_write(8'h14, 32'h3);
        bus_write(8'h00, 32'h2);
        bus_read(8'h04, v);
        chk(v == ST_RSD, "R6 reseeding status", v, ST_RSD);
        chk(irq == 1'b0, "R9 irq low without enables", 32'(irq), 32'h0);
        wait_idle();
        bus_read(8'h14, v);
        chk(v == 32'h2, "R8 seed flag set with irq disabled", v, 32'h2);
    endtask

    task automatic t_w1c();
        int n;
        logic [31:0] v;
        run_gen(1'b0, n);
        bus_write(8'h10, 32'h0);
        bus_read(8'h14, v);
        chk(v == 32'h3, "R8 both flags set", v, 32'h3);
        bus_write(8'h14, 32'h0);
        bus_read(8'h14, v);
        chk(v == 32'h3, "R8 write zero keeps flags", v, 32'h3);
        bus_write(8'h14, 32'h1);
        bus_read(8'h14, v);
        chk(v == 32'h2, "R8 clear ready only", v, 32'h2);
    endtask

    task automatic t_irq();
        bus_write(8'h10, 32'h0000_0002);
        chk(irq == 1'b0, "R9 no global enable", 32'(irq), 32'h0);
        bus_write(8'h10, 32'h8000_0002);
        chk(irq == 1'b1, "R9 seed-done routed", 32'(irq), 32'h1);
        bus_write(8'h10, 32'h8000_0001);
        chk(irq == 1'b0, "R9 ready enable with ready clear", 32'(irq), 32'h0);
        bus_write(8'h14, 32'h2);
        bus_write(8'h10, 32'h8000_0002);
        chk(irq == 1'b0, "R9 seed flag cleared", 32'(irq), 32'h0);
    endtask

    task automatic t_auto();
        int n;
        logic [31:0] v;
        bus_write(8'h60, 32'd3);
        for (int k = 0; k < 3; k++) begin
            run_gen(1'b0, n);
            bus_read(8'h04, v);
            if (k < 2) chk(v == ST_IDLE, "R10 below limit idle", v, ST_IDLE);
            else       chk(v == ST_RSD, "R10 auto reseed at 3 units", v, ST_RSD);
        end
        wait_idle();
        bus_write(8'h60, 32'd4);
        run_gen(1'b1, n);
        bus_read(8'h04, v);
        chk(v == ST_IDLE, "R10 two units idle", v, ST_IDLE);
        run_gen(1'b1, n);
        bus_read(8'h04, v);
        chk(v == ST_RSD, "R10 four units reseed", v, ST_RSD);
        wait_idle();
        bus_write(8'h60, 32'd0);
        run_gen(1'b1, n);
        bus_read(8'h04, v);
        chk(v == ST_IDLE, "R10 limit zero disables", v, ST_IDLE);
    endtask

    task automatic t_cmd0();
        logic [31:0] w0, w1, v;
        bus_read(8'h20, w0);
        bus_write(8'h00, 32'h0);
        bus_read(8'h04, v);
        chk(v == ST_IDLE, "R12 nop keeps status", v, ST_IDLE);
        bus_read(8'h20, w1);
        chk(w1 == w0, "R12 nop keeps data", w1, w0);
    endtask

    task automatic t_determinism();
        int n;
        do_reset();
        wait_idle();
        run_gen(1'b1, n);
        read_words();
        for (int i = 0; i < 8; i++)
            chk(cur_words[i] == first_words[i], "R11 same words after reset", cur_words[i], first_words[i]);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gen256();
        t_status_gen();
        t_gen128();
        t_busy_ignore();
        t_reseed();
        t_w1c();
        t_irq();
        t_auto();
        t_cmd0();
        t_determinism();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule